// File: doc/BRIEF.md
# PC reuse predictor table

This block keeps, for each instruction that issues cache requests, a history of how often the addresses it brought in were later requested again. The history sits in a tagless table selected by a slice of the requesting PC. Each entry holds a saturating count of addresses that showed reuse and a count of addresses that did not. The tracking structure that watches recently missed addresses sends the block an update whenever it learns the fate of an address that a PC inserted.

Each lookup returns two decisions, two cycles after the lookup is accepted. The first decision says whether a first-time request from this PC should be kept in the last-level cache instead of bypassing it. The second says whether the request's address should be entered into the address tracking structure. PCs whose reuse fraction is very high or very low only get one insertion in eight. A shared 3-bit sampler picks which lookups may insert. Counts are compared with shifts and additions, so no divider is needed.

Top module: `pc_reuse_predictor`

## Requirements
- R1: After synchronous reset every entry reads as reused=0 and not-reused=0, the sampler is at zero, and rsp_valid, rsp_store and rsp_insert are 0.
- R2: The entry is selected by PC bits [9:2] only and there is no tag, so two PCs that agree in those bits share one entry.
- R3: An update with upd_reused=1 adds one to the reused count of the selected entry, and an update with upd_reused=0 adds one to its not-reused count.
- R4: Counts are 10 bits wide. When an increment would bring a count to 1023, both counts of that entry are stored halved, rounding down, so the incremented count becomes 511.
- R5: A lookup accepted in cycle t gives rsp_valid=1 in cycle t+2. rsp_store is 1 exactly when 4*reused > reused + not-reused.
- R6: A lookup is extreme when 4*reused > reused + not-reused or 64*reused < reused + not-reused. A non-extreme lookup, including one on an all-zero entry, always gives rsp_insert=1.
- R7: An extreme lookup gives rsp_insert=1 only when the 3-bit sampler reads 0. Each extreme lookup then advances the sampler by one, modulo 8. Non-extreme lookups leave the sampler unchanged.
- R8: When an update and a lookup select the same entry in the same cycle, the lookup is answered from the counts before the update, and the update is still applied.
- R9: rsp_store and rsp_insert are 0 whenever rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Lookup request strobe |
| q_pc | input | 32 | PC of the requesting instruction |
| upd_valid | input | 1 | Reuse outcome update strobe |
| upd_pc | input | 32 | PC that inserted the address whose outcome is reported |
| upd_reused | input | 1 | 1 = address was reused, 0 = address was evicted unused |
| rsp_valid | output | 1 | Decisions valid, two cycles after q_valid |
| rsp_store | output | 1 | Store first request in the cache instead of bypassing |
| rsp_insert | output | 1 | Insert the address into the address tracking structure |

## Verification
A lookup and an outcome update can land on the same entry in the same clock. The bench provokes this by driving both strobes in one cycle with identical PCs on an all-zero entry. That first lookup must return the neutral answer of an empty entry. A lookup issued afterwards must see the reused count of one and report store. Halving is reached by a long run of back-to-back updates. The check uses a reused count whose rounding moves the entry across the 1/64 boundary only when halving is done correctly.

// File: rtl/pcrt_pkg.sv
package pcrt_pkg;
  // Default geometry of the predictor
  parameter int unsigned PCRT_PC_W    = 32;
  parameter int unsigned PCRT_IDX_W   = 8;
  parameter int unsigned PCRT_IDX_LSB = 2;
  parameter int unsigned PCRT_CNT_W   = 10;
  parameter int unsigned PCRT_SAMP_W  = 3;
  // Threshold shifts: high when r<<HI > total, low when r<<LO < total
  parameter int unsigned PCRT_HI_SHIFT = 2;
  parameter int unsigned PCRT_LO_SHIFT = 6;

  typedef enum logic [1:0] {
    REUSE_MID  = 2'd0,
    REUSE_HIGH = 2'd1,
    REUSE_LOW  = 2'd2
  } reuse_class_e;
endpackage

// File: rtl/pcrt_entry_store.sv
module pcrt_entry_store #(
  parameter int unsigned IDX_W = pcrt_pkg::PCRT_IDX_W,
  parameter int unsigned CNT_W = pcrt_pkg::PCRT_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_reused,
  input  logic             rd_valid,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_q_valid,
  output logic [CNT_W-1:0] rd_reused,
  output logic [CNT_W-1:0] rd_notreused
);
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned WORD_W = 2 * CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_MAX >> 1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // Resetless storage: {reused, notreused}
  logic [WORD_W-1:0] mem [DEPTH];
  // Per-entry written flag; an unwritten entry reads as zero counts
  logic [DEPTH-1:0]  written;

  logic [WORD_W-1:0] rd_word;
  logic              rd_written;

  logic [WORD_W-1:0] old_word;
  logic [CNT_W-1:0]  old_r, old_n, inc_r, inc_n, new_r, new_n;
  logic              hit_max;

  always_comb begin
    old_word = mem[upd_idx];
    old_r    = written[upd_idx] ? old_word[WORD_W-1:CNT_W] : '0;
    old_n    = written[upd_idx] ? old_word[CNT_W-1:0]      : '0;
    inc_r    = upd_reused  ? old_r + CNT_ONE : old_r;
    inc_n    = !upd_reused ? old_n + CNT_ONE : old_n;
    hit_max  = upd_reused ? (inc_r == CNT_MAX) : (inc_n == CNT_MAX);
    new_r    = hit_max ? (inc_r >> 1) : inc_r;
    new_n    = hit_max ? (inc_n >> 1) : inc_n;
  end

  // Write port and registered read port (read returns pre-write data)
  always_ff @(posedge clk) begin
    if (upd_valid) begin
      mem[upd_idx] <= {new_r, new_n};
    end
    rd_word <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written    <= '0;
      rd_written <= 1'b0;
      rd_q_valid <= 1'b0;
    end else begin
      if (upd_valid) begin
        written[upd_idx] <= 1'b1;
      end
      rd_written <= written[rd_idx];
      rd_q_valid <= rd_valid;
    end
  end

  assign rd_reused    = rd_written ? rd_word[WORD_W-1:CNT_W] : '0;
  assign rd_notreused = rd_written ? rd_word[CNT_W-1:0]      : '0;

  // R4: a stored count never sits at the maximum
  assert_no_saturation_R4: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (mem[$past(upd_idx)][WORD_W-1:CNT_W] != CNT_MAX) &&
                  (mem[$past(upd_idx)][CNT_W-1:0] != CNT_MAX))
    else $error("count reached maximum");

  // R4: reaching the maximum on the reused side leaves half of it
  assert_halve_on_max_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_reused && old_r == CNT_MAX - CNT_ONE)
      |=> mem[$past(upd_idx)][WORD_W-1:CNT_W] == CNT_HALF)
    else $error("halving did not happen");

  // R3: an update marks its entry as written
  assert_update_marks_R3: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> written[$past(upd_idx)])
    else $error("updated entry not marked");
endmodule

// File: rtl/pcrt_classify.sv
module pcrt_classify #(
  parameter int unsigned CNT_W    = pcrt_pkg::PCRT_CNT_W,
  parameter int unsigned HI_SHIFT = pcrt_pkg::PCRT_HI_SHIFT,
  parameter int unsigned LO_SHIFT = pcrt_pkg::PCRT_LO_SHIFT
) (
  input  logic [CNT_W-1:0]     reused,
  input  logic [CNT_W-1:0]     notreused,
  output pcrt_pkg::reuse_class_e cls
);
  localparam int unsigned SH_MAX = (HI_SHIFT > LO_SHIFT) ? HI_SHIFT : LO_SHIFT;
  localparam int unsigned PW     = CNT_W + SH_MAX + 1;

  logic [PW-1:0] r_ext, total, r_hi, r_lo;
  logic          is_high, is_low;

  always_comb begin
    r_ext   = PW'(reused);
    total   = PW'(reused) + PW'(notreused);
    r_hi    = r_ext << HI_SHIFT;
    r_lo    = r_ext << LO_SHIFT;
    is_high = r_hi > total;
    is_low  = r_lo < total;
    if (is_high)     cls = pcrt_pkg::REUSE_HIGH;
    else if (is_low) cls = pcrt_pkg::REUSE_LOW;
    else             cls = pcrt_pkg::REUSE_MID;
  end

  // R6: an empty entry is never extreme
  always_comb begin
    if (reused == '0 && notreused == '0) begin
      assert_empty_is_mid_R6: assert (cls == pcrt_pkg::REUSE_MID)
        else $error("empty entry classified extreme");
    end
  end
endmodule

// File: rtl/pcrt_sampler.sv
module pcrt_sampler #(
  parameter int unsigned SAMP_W = pcrt_pkg::PCRT_SAMP_W
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic permit
);
  logic [SAMP_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (advance) begin
      phase <= phase + SAMP_W'(1);
    end
  end

  assign permit = (phase == '0);

  // R7: a granted slot is followed by a closed one
  assert_grant_then_closed_R7: assert property (@(posedge clk) disable iff (rst)
    (advance && permit) |=> !permit)
    else $error("sampler granted twice in a row");

  // R7: idle sampler keeps its phase
  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(permit))
    else $error("sampler moved without extreme lookup");
endmodule

// File: rtl/pc_reuse_predictor.sv
module pc_reuse_predictor #(
  parameter int unsigned PC_W    = pcrt_pkg::PCRT_PC_W,
  parameter int unsigned IDX_W   = pcrt_pkg::PCRT_IDX_W,
  parameter int unsigned IDX_LSB = pcrt_pkg::PCRT_IDX_LSB,
  parameter int unsigned CNT_W   = pcrt_pkg::PCRT_CNT_W,
  parameter int unsigned SAMP_W  = pcrt_pkg::PCRT_SAMP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            q_valid,
  input  logic [PC_W-1:0] q_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_reused,
  output logic            rsp_valid,
  output logic            rsp_store,
  output logic            rsp_insert
);
  import pcrt_pkg::*;

  logic [IDX_W-1:0] q_idx, u_idx;
  assign q_idx = q_pc[IDX_LSB +: IDX_W];
  assign u_idx = upd_pc[IDX_LSB +: IDX_W];

  logic             s1_valid;
  logic [CNT_W-1:0] s1_r, s1_n;
  reuse_class_e     s1_cls;
  logic             s1_extreme, samp_permit;

  pcrt_entry_store #(.IDX_W(IDX_W), .CNT_W(CNT_W)) store_i (
    .clk(clk), .rst(rst),
    .upd_valid(upd_valid), .upd_idx(u_idx), .upd_reused(upd_reused),
    .rd_valid(q_valid), .rd_idx(q_idx),
    .rd_q_valid(s1_valid), .rd_reused(s1_r), .rd_notreused(s1_n)
  );

  pcrt_classify #(.CNT_W(CNT_W)) cls_i (
    .reused(s1_r), .notreused(s1_n), .cls(s1_cls)
  );

  assign s1_extreme = (s1_cls != REUSE_MID);

  pcrt_sampler #(.SAMP_W(SAMP_W)) samp_i (
    .clk(clk), .rst(rst),
    .advance(s1_valid && s1_extreme),
    .permit(samp_permit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_store  <= 1'b0;
      rsp_insert <= 1'b0;
    end else begin
      rsp_valid  <= s1_valid;
      rsp_store  <= s1_valid && (s1_cls == REUSE_HIGH);
      rsp_insert <= s1_valid && (!s1_extreme || samp_permit);
    end
  end

  // R5: response two cycles after a lookup
  assert_resp_latency_R5: assert property (@(posedge clk) disable iff (rst)
    q_valid |=> ##1 rsp_valid)
    else $error("response missing");

  // R6: a non-extreme lookup inserts and does not store
  assert_mid_inserts_R6: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_extreme) |=> rsp_insert && !rsp_store)
    else $error("mid lookup not inserted");

  // R9: decisions quiet without a response
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_store && !rsp_insert))
    else $error("decision without response");
endmodule

// File: tb/pc_reuse_predictor_tb_top.sv
module pc_reuse_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        q_valid = 1'b0;
  logic [31:0] q_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_reused = 1'b0;
  logic        rsp_valid, rsp_store, rsp_insert;

  int total = 0;
  int bad = 0;

  // Bench model of the requirements
  int mr [256];
  int mn [256];
  int msamp = 0;

  always #4 clk = ~clk;

  pc_reuse_predictor dut_i (
    .clk(clk), .rst(rst),
    .q_valid(q_valid), .q_pc(q_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_reused(upd_reused),
    .rsp_valid(rsp_valid), .rsp_store(rsp_store), .rsp_insert(rsp_insert)
  );

  function automatic logic [31:0] pc_of(int idx, int hi);
    return {hi[21:0], idx[7:0], 2'b00};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_update(int idx, bit reused);
    int r = mr[idx];
    int n = mn[idx];
    if (reused) r++; else n++;
    if (r == 1023 || n == 1023) begin
      r = r / 2;
      n = n / 2;
    end
    mr[idx] = r;
    mn[idx] = n;
  endfunction

  // Returns {store, insert} and advances the model sampler
  function automatic logic [1:0] model_query(int idx);
    int r = mr[idx];
    int n = mn[idx];
    bit hi = (4 * r) > (r + n);
    bit lo = (64 * r) < (r + n);
    bit ins;
    if (hi || lo) begin
      ins = (msamp == 0);
      msamp = (msamp + 1) % 8;
    end else begin
      ins = 1'b1;
    end
    return {hi, ins};
  endfunction

  task automatic do_update(logic [31:0] pc, bit reused);
    upd_valid  = 1'b1;
    upd_pc     = pc;
    upd_reused = reused;
    model_update(int'(pc[9:2]), reused);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_query(logic [31:0] pc, string req);
    logic [1:0] e;
    e = model_query(int'(pc[9:2]));
    q_valid = 1'b1;
    q_pc    = pc;
    @(negedge clk);
    q_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b1, {req, " valid"}, rsp_valid, 1);
    check(rsp_store == e[1], {req, " store"}, rsp_store, e[1]);
    check(rsp_insert == e[0], {req, " insert"}, rsp_insert, e[0]);
  endtask

  task automatic t_reset;
    check(!rsp_valid && !rsp_store && !rsp_insert, "R1 outputs after reset",
          {rsp_valid, rsp_store, rsp_insert}, 0);
    do_query(pc_of(5, 0), "R1 empty entry");
  endtask

  task automatic t_fresh;
    do_query(pc_of(7, 3), "R6 all-zero entry mid");
  endtask

  task automatic t_count_store;
    do_update(pc_of(10, 0), 1'b1);
    do_update(pc_of(10, 0), 1'b0);
    do_update(pc_of(10, 0), 1'b0);
    do_query(pc_of(10, 0), "R3 R5 r1 n2 above quarter");
    do_update(pc_of(10, 0), 1'b0);
    do_query(pc_of(10, 0), "R5 r1 n3 at quarter no store");
  endtask

  task automatic t_alias;
    do_update(pc_of(12, 0), 1'b1);
    do_query(pc_of(12, 77), "R2 alias shares entry");
    do_query(pc_of(13, 0), "R2 neighbour untouched");
  endtask

  task automatic t_sampling;
    do_update(pc_of(20, 0), 1'b1);
    for (int i = 0; i < 11; i++) begin
      do_query(pc_of(20, 0), "R7 sampled insert high");
      if (i == 4) do_query(pc_of(7, 0), "R7 mid does not advance");
    end
  endtask

  task automatic t_low;
    do_update(pc_of(30, 0), 1'b1);
    for (int i = 0; i < 63; i++) do_update(pc_of(30, 0), 1'b0);
    do_query(pc_of(30, 0), "R6 r1 n63 boundary mid");
    do_update(pc_of(30, 0), 1'b0);
    for (int i = 0; i < 9; i++) do_query(pc_of(30, 0), "R7 below 1/64 sampled");
  endtask

  task automatic t_same_cycle;
    logic [1:0] e;
    e = model_query(40);
    q_valid    = 1'b1;
    q_pc       = pc_of(40, 0);
    upd_valid  = 1'b1;
    upd_pc     = pc_of(40, 0);
    upd_reused = 1'b1;
    model_update(40, 1'b1);
    @(negedge clk);
    q_valid   = 1'b0;
    upd_valid = 1'b0;
    @(negedge clk);
    check(rsp_store == e[1], "R8 old counts store", rsp_store, e[1]);
    check(rsp_insert == e[0], "R8 old counts insert", rsp_insert, e[0]);
    do_query(pc_of(40, 0), "R8 update applied");
  endtask

  task automatic t_halve;
    for (int i = 0; i < 17; i++) do_update(pc_of(50, 0), 1'b1);
    for (int i = 0; i < 1022; i++) do_update(pc_of(50, 0), 1'b0);
    do_query(pc_of(50, 0), "R4 r17 n1022 before halving");
    do_update(pc_of(50, 0), 1'b0);
    do_query(pc_of(50, 0), "R4 halved r8 n511");
    do_query(pc_of(50, 0), "R4 halved second look");
  endtask

  task automatic t_idle;
    do_query(pc_of(10, 0), "R9 lookup");
    @(negedge clk);
    check(!rsp_valid && !rsp_store && !rsp_insert, "R9 quiet after response",
          {rsp_valid, rsp_store, rsp_insert}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mr[i] = 0;
      mn[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fresh();
    t_count_store();
    t_alias();
    t_sampling();
    t_low();
    t_same_cycle();
    t_halve();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule